// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Core

This block holds the programming state of a four-channel DMA engine and answers per-byte address requests from the transfer side. A host reaches it through an 8-bit register window with a 4-bit register address. Each channel has a 16-bit current address, a 16-bit remaining count and reload copies of both. Mask, software request, mode and command settings sit beside them, with a status byte that reports terminal count. The host loads the 16-bit channel registers as two bytes through one byte pointer that all four channels share.

On the transfer side a client names a channel and raises a request. In the same cycle the block either grants the request and presents a 24-bit byte address, or refuses it. The address is the channel's page byte above its current 16-bit address. A grant moves the address one step up or down, as the channel's mode selects, and takes one off the count. When the count wraps below zero the channel raises terminal count and stops granting until software reads the status byte. A channel in autoinitialise mode also reloads its address and count at that point.

Top module: `dma4_regif`

## Requirements
- R1: After reset every channel is masked, all terminal-count and request flags and the command value are zero, and a transfer request on any channel is refused.
- R2: Host addresses 0 to 7 reach the channel registers: address bits [2:1] pick the channel and bit 0 picks the count (1) or the address (0). Each access carries one byte. The shared pointer makes it the low byte first, then the high byte, and toggles after every access. A write loads both the current and the reload copy. A read returns the current value.
- R3: A write to address 12 points the shared byte pointer back at the low byte.
- R4: Masks: a write to address 10 sets channel data[1:0] to mask value data[2]. A write to address 14 unmasks all channels. A write to address 15 loads channel n's mask from data bit n.
- R5: A write to address 9 sets the software request of channel data[1:0] to data[2]. Request flags appear in status bits [7:4], channel n in bit 4+n.
- R6: A write to address 11 programs channel data[1:0]. Data[3:2] is the stored transfer type, data[4] enables autoinitialise and data[5] makes the address step down instead of up.
- R7: A write to address 8 stores command bits data[2:0]: memory-to-memory, channel 0 address hold and controller enable. A read of address 9 returns them in bits [2:0], with zeros above.
- R8: A read of address 8 returns the status byte, with terminal count of channel n in bit n. All terminal-count flags then clear, except one that a grant sets in that same cycle.
- R9: A transfer request is granted (xfer_ok high) in the same cycle only when the channel is unmasked and its terminal count is clear. A granted address is {page, current address}, and xfer_addr is zero when there is no grant. Page n is written through the page port.
- R10: Each grant steps the current address by one in the mode direction and decrements the count. A refused request changes nothing.
- R11: A grant made with a count of zero sets terminal count. Without autoinitialise the address still steps and the count wraps to all ones. Later requests on that channel are refused.
- R12: With autoinitialise, the grant that sets terminal count reloads the current address and count from their reload copies.
- R13: A write to address 13 resets the byte pointer, masks every channel and clears every request and terminal-count flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the read cycle, else zero |
| page_we | input | 1 | Page register write strobe |
| page_ch | input | 2 | Page register channel |
| page_data | input | 8 | Page value, address bits [23:16] |
| xfer_req | input | 1 | Transfer side asks for the next byte address |
| xfer_ch | input | 2 | Requesting channel |
| xfer_ok | output | 1 | Request granted this cycle |
| xfer_addr | output | 24 | Granted byte address, zero when refused |

## Verification
The bench uses the package defaults: four channels, 16-bit address and count, 8-bit page and data. With these values a two-byte count reaches terminal count in a few grants, and both step directions, the wrap to all ones and the autoinitialise reload all occur within a short run. A 4-bit host address covers every register, so each command strobe and the pointer toggle shared across channels can be exercised directly. The bench's behavioural model is compared against the read data and the grant outputs on every clock.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int AW  = 16;
    localparam int PW  = 8;
    localparam int DW  = 8;
    localparam int RAW = 4;
    localparam int FAW = AW + PW;
    localparam int CMDW = 3;

    localparam logic [RAW-1:0] A_CMDSTS  = 4'd8;
    localparam logic [RAW-1:0] A_REQ     = 4'd9;
    localparam logic [RAW-1:0] A_MASK1   = 4'd10;
    localparam logic [RAW-1:0] A_MODE    = 4'd11;
    localparam logic [RAW-1:0] A_PTRRST  = 4'd12;
    localparam logic [RAW-1:0] A_MRESET  = 4'd13;
    localparam logic [RAW-1:0] A_UNMASK  = 4'd14;
    localparam logic [RAW-1:0] A_MASKALL = 4'd15;

    typedef struct packed {
        logic [AW-1:0] cur_addr;
        logic [AW-1:0] base_addr;
        logic [AW-1:0] cur_cnt;
        logic [AW-1:0] base_cnt;
        logic [PW-1:0] page;
        logic          mask;
        logic          sreq;
        logic          tc;
        logic          autoinit;
        logic          down;
        logic [1:0]    xtype;
    } chan_t;

    typedef struct packed {
        chan_t [NCH-1:0] ch;
        logic            ptr_hi;
        logic [CMDW-1:0] cmd;
    } regs_t;

    typedef struct packed {
        logic chreg_wr;
        logic chreg_rd;
        logic sts_rd;
        logic cmd_wr;
        logic cmd_rd;
        logic req_wr;
        logic mask1_wr;
        logic mode_wr;
        logic ptr_rst;
        logic mreset;
        logic unmask;
        logic maskall;
    } strobe_t;
endpackage

// File: rtl/dma4_decode.sv
module dma4_decode
    import dma4_pkg::*;
(
    input  logic           sel,
    input  logic           we,
    input  logic [RAW-1:0] addr,
    output strobe_t        stb
);
    logic is_chreg;
    logic wr;
    logic rd;

    always_comb begin
        is_chreg = !addr[RAW-1];
        wr = sel && we;
        rd = sel && !we;
        stb = '0;
        stb.chreg_wr = wr && is_chreg;
        stb.chreg_rd = rd && is_chreg;
        stb.sts_rd   = rd && (addr == A_CMDSTS);
        stb.cmd_rd   = rd && (addr == A_REQ);
        stb.cmd_wr   = wr && (addr == A_CMDSTS);
        stb.req_wr   = wr && (addr == A_REQ);
        stb.mask1_wr = wr && (addr == A_MASK1);
        stb.mode_wr  = wr && (addr == A_MODE);
        stb.ptr_rst  = wr && (addr == A_PTRRST);
        stb.mreset   = wr && (addr == A_MRESET);
        stb.unmask   = wr && (addr == A_UNMASK);
        stb.maskall  = wr && (addr == A_MASKALL);
    end
endmodule

// File: rtl/dma4_chan_step.sv
module dma4_chan_step
    import dma4_pkg::*;
(
    input  chan_t cur,
    input  logic  grant,
    output chan_t nxt,
    output logic  avail
);
    logic [AW-1:0] stepped;

    always_comb begin
        avail   = !cur.mask && !cur.tc;
        stepped = cur.down ? (cur.cur_addr - 1'b1) : (cur.cur_addr + 1'b1);
        nxt     = cur;
        if (grant) begin
            if (cur.cur_cnt == '0) begin
                nxt.tc = 1'b1;
                if (cur.autoinit) begin
                    nxt.cur_addr = cur.base_addr;
                    nxt.cur_cnt  = cur.base_cnt;
                end else begin
                    nxt.cur_addr = stepped;
                    nxt.cur_cnt  = '1;
                end
            end else begin
                nxt.cur_addr = stepped;
                nxt.cur_cnt  = cur.cur_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma4_regif.sv
module dma4_regif
    import dma4_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_sel,
    input  logic           host_we,
    input  logic [RAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    input  logic           page_we,
    input  logic [CHW-1:0] page_ch,
    input  logic [PW-1:0]  page_data,
    input  logic           xfer_req,
    input  logic [CHW-1:0] xfer_ch,
    output logic           xfer_ok,
    output logic [FAW-1:0] xfer_addr
);
    regs_t           state_d;
    regs_t           state_q;
    strobe_t         stb;
    chan_t [NCH-1:0] step_nxt;
    logic [NCH-1:0]  avail;
    logic [NCH-1:0]  grant;
    logic [NCH-1:0]  mask_vec;
    logic [NCH-1:0]  tc_vec;
    logic            ptr_q;

    dma4_decode u_decode (
        .sel  (host_sel),
        .we   (host_we),
        .addr (host_addr),
        .stb  (stb)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign grant[i] = xfer_req && (xfer_ch == CHW'(i)) && avail[i];
        dma4_chan_step u_step (
            .cur   (state_q.ch[i]),
            .grant (grant[i]),
            .nxt   (step_nxt[i]),
            .avail (avail[i])
        );
    end

    // next-state: status clear, then transfer steps, then host writes
    always_comb begin
        logic [CHW-1:0] hch;
        logic [CHW-1:0] dch;
        logic [AW-1:0]  oldv;
        logic [AW-1:0]  newv;

        hch  = host_addr[CHW:1];
        dch  = host_wdata[CHW-1:0];
        oldv = host_addr[0] ? state_q.ch[hch].cur_cnt : state_q.ch[hch].cur_addr;
        newv = state_q.ptr_hi ? {host_wdata, oldv[DW-1:0]} : {oldv[AW-1:DW], host_wdata};

        state_d = state_q;
        for (int i = 0; i < NCH; i++) begin
            state_d.ch[i] = step_nxt[i];
            if (stb.sts_rd && !grant[i]) begin
                state_d.ch[i].tc = 1'b0;
            end
        end

        if (page_we) begin
            state_d.ch[page_ch].page = page_data;
        end

        if (stb.chreg_wr || stb.chreg_rd) begin
            state_d.ptr_hi = !state_q.ptr_hi;
        end
        if (stb.chreg_wr) begin
            if (host_addr[0]) begin
                state_d.ch[hch].cur_cnt  = newv;
                state_d.ch[hch].base_cnt = newv;
            end else begin
                state_d.ch[hch].cur_addr  = newv;
                state_d.ch[hch].base_addr = newv;
            end
        end
        if (stb.cmd_wr) begin
            state_d.cmd = host_wdata[CMDW-1:0];
        end
        if (stb.req_wr) begin
            state_d.ch[dch].sreq = host_wdata[CHW];
        end
        if (stb.mask1_wr) begin
            state_d.ch[dch].mask = host_wdata[CHW];
        end
        if (stb.mode_wr) begin
            state_d.ch[dch].xtype    = host_wdata[3:2];
            state_d.ch[dch].autoinit = host_wdata[4];
            state_d.ch[dch].down     = host_wdata[5];
        end
        if (stb.ptr_rst) begin
            state_d.ptr_hi = 1'b0;
        end
        if (stb.unmask) begin
            for (int i = 0; i < NCH; i++) state_d.ch[i].mask = 1'b0;
        end
        if (stb.maskall) begin
            for (int i = 0; i < NCH; i++) state_d.ch[i].mask = host_wdata[i];
        end
        if (stb.mreset) begin
            state_d.ptr_hi = 1'b0;
            for (int i = 0; i < NCH; i++) begin
                state_d.ch[i].mask = 1'b1;
                state_d.ch[i].sreq = 1'b0;
                state_d.ch[i].tc   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            for (int i = 0; i < NCH; i++) state_q.ch[i].mask <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        logic [CHW-1:0] hch;
        logic [AW-1:0]  rv;

        hch = host_addr[CHW:1];
        rv  = host_addr[0] ? state_q.ch[hch].cur_cnt : state_q.ch[hch].cur_addr;
        for (int i = 0; i < NCH; i++) begin
            mask_vec[i] = state_q.ch[i].mask;
            tc_vec[i]   = state_q.ch[i].tc;
        end
        ptr_q = state_q.ptr_hi;

        host_rdata = '0;
        if (stb.chreg_rd) begin
            host_rdata = state_q.ptr_hi ? rv[AW-1:DW] : rv[DW-1:0];
        end else if (stb.sts_rd) begin
            for (int i = 0; i < NCH; i++) begin
                host_rdata[i]       = state_q.ch[i].tc;
                host_rdata[NCH + i] = state_q.ch[i].sreq;
            end
        end else if (stb.cmd_rd) begin
            host_rdata[CMDW-1:0] = state_q.cmd;
        end

        xfer_ok   = |grant;
        xfer_addr = xfer_ok ? {state_q.ch[xfer_ch].page, state_q.ch[xfer_ch].cur_addr} : '0;
    end
endmodule

// File: rtl/dma4_regif_chk.sv
module dma4_regif_chk
    import dma4_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           host_sel,
    input logic           host_we,
    input logic [RAW-1:0] host_addr,
    input logic           xfer_req,
    input logic [CHW-1:0] xfer_ch,
    input logic           xfer_ok,
    input logic [NCH-1:0] mask_vec,
    input logic [NCH-1:0] tc_vec,
    input logic           ptr_q
);
    a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_we && host_addr == A_CMDSTS && !xfer_req) |=> (tc_vec == '0));

    a_r4_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_we && host_addr == A_UNMASK) |=> (mask_vec == '0));

    a_r13_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_we && host_addr == A_MRESET) |=> (mask_vec == '1 && tc_vec == '0 && !ptr_q));

    a_r3_pointer_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_we && host_addr == A_PTRRST) |=> !ptr_q);

    a_r11_tc_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && tc_vec[xfer_ch]) |-> !xfer_ok);

    a_r9_mask_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && mask_vec[xfer_ch]) |-> !xfer_ok);
endmodule

bind dma4_regif dma4_regif_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_we   (host_we),
    .host_addr (host_addr),
    .xfer_req  (xfer_req),
    .xfer_ch   (xfer_ch),
    .xfer_ok   (xfer_ok),
    .mask_vec  (mask_vec),
    .tc_vec    (tc_vec),
    .ptr_q     (ptr_q)
);

// File: tb/test_dma4_regif.sv
`timescale 1ns/1ps
module test_dma4_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        page_we = 1'b0;
    logic [1:0]  page_ch = '0;
    logic [7:0]  page_data = '0;
    logic        xfer_req = 1'b0;
    logic [1:0]  xfer_ch = '0;
    logic        xfer_ok;
    logic [23:0] xfer_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dma4_regif i_dma4_regif (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .page_we(page_we), .page_ch(page_ch), .page_data(page_data),
        .xfer_req(xfer_req), .xfer_ch(xfer_ch),
        .xfer_ok(xfer_ok), .xfer_addr(xfer_addr)
    );

    // behavioural reference model
    int m_adr[4], m_badr[4], m_cnt[4], m_bcnt[4], m_page[4];
    bit m_mask[4], m_req[4], m_tc[4], m_auto[4], m_down[4];
    int m_cmd;
    bit m_hi;

    function automatic int model_status();
        int s = 0;
        for (int i = 0; i < 4; i++) begin
            if (m_tc[i])  s |= (1 << i);
            if (m_req[i]) s |= (1 << (4 + i));
        end
        return s;
    endfunction

    function automatic int model_rdata();
        int v;
        if (!host_sel || host_we) return 0;
        if (host_addr < 8) begin
            v = host_addr[0] ? m_cnt[host_addr >> 1] : m_adr[host_addr >> 1];
            return m_hi ? ((v >> 8) & 255) : (v & 255);
        end
        if (host_addr == 8) return model_status();
        if (host_addr == 9) return m_cmd;
        return 0;
    endfunction

    function automatic bit model_ok();
        return xfer_req && !m_mask[xfer_ch] && !m_tc[xfer_ch];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_adr[i] = 0; m_badr[i] = 0; m_cnt[i] = 0; m_bcnt[i] = 0; m_page[i] = 0;
                m_mask[i] = 1; m_req[i] = 0; m_tc[i] = 0; m_auto[i] = 0; m_down[i] = 0;
            end
            m_cmd = 0; m_hi = 0;
        end else begin
            bit ok;
            int c;
            int b;
            ok = model_ok();
            c = xfer_ch;
            if (host_sel && !host_we && host_addr == 8)
                for (int i = 0; i < 4; i++) m_tc[i] = 0;
            if (ok) begin
                if (m_cnt[c] == 0) begin
                    m_tc[c] = 1;
                    if (m_auto[c]) begin
                        m_adr[c] = m_badr[c]; m_cnt[c] = m_bcnt[c];
                    end else begin
                        m_adr[c] = (m_adr[c] + (m_down[c] ? -1 : 1)) & 16'hFFFF;
                        m_cnt[c] = 16'hFFFF;
                    end
                end else begin
                    m_adr[c] = (m_adr[c] + (m_down[c] ? -1 : 1)) & 16'hFFFF;
                    m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (page_we) m_page[page_ch] = page_data;
            if (host_sel) begin
                c = host_addr >> 1;
                b = host_wdata[1:0];
                if (host_addr < 8) begin
                    if (host_we) begin
                        int v;
                        v = host_addr[0] ? m_cnt[c] : m_adr[c];
                        v = m_hi ? ((v & 255) | (host_wdata << 8)) : ((v & 16'hFF00) | host_wdata);
                        if (host_addr[0]) begin m_cnt[c] = v; m_bcnt[c] = v; end
                        else begin m_adr[c] = v; m_badr[c] = v; end
                    end
                    m_hi = !m_hi;
                end else if (host_we) begin
                    case (host_addr)
                        8:  m_cmd = host_wdata & 7;
                        9:  m_req[b] = host_wdata[2];
                        10: m_mask[b] = host_wdata[2];
                        11: begin m_auto[b] = host_wdata[4]; m_down[b] = host_wdata[5]; end
                        12: m_hi = 0;
                        13: begin
                            m_hi = 0;
                            for (int i = 0; i < 4; i++) begin m_mask[i] = 1; m_req[i] = 0; m_tc[i] = 0; end
                        end
                        14: for (int i = 0; i < 4; i++) m_mask[i] = 0;
                        15: for (int i = 0; i < 4; i++) m_mask[i] = host_wdata[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic check(input int act, input int exp, input string rq);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ea;
            ea = model_ok() ? ((m_page[xfer_ch] << 16) | m_adr[xfer_ch]) : 0;
            check(host_rdata, model_rdata(), {tag, " rdata"});
            check(xfer_ok, model_ok(), {tag, " ok"});
            check(xfer_addr, ea, {tag, " addr"});
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        host_sel = 0; host_we = 0; page_we = 0; xfer_req = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        page_we = 0; xfer_req = 0;
        host_sel = 1; host_we = 1; host_addr = 4'(a); host_wdata = 8'(d);
    endtask

    task automatic rd(input int a, input int exp, input string rq);
        @(posedge clk); #1;
        page_we = 0; xfer_req = 0;
        host_sel = 1; host_we = 0; host_addr = 4'(a);
        @(negedge clk);
        check(host_rdata, exp, rq);
    endtask

    task automatic setpage(input int c, input int p);
        @(posedge clk); #1;
        host_sel = 0; xfer_req = 0;
        page_we = 1; page_ch = 2'(c); page_data = 8'(p);
    endtask

    task automatic xfer(input int c, input bit eok, input int ea, input string rq);
        @(posedge clk); #1;
        host_sel = 0; page_we = 0;
        xfer_req = 1; xfer_ch = 2'(c);
        @(negedge clk);
        check(xfer_ok, eok, rq);
        check(xfer_addr, ea, rq);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        tag = "R1";
        rd(8, 8'h00, "R1");
        rd(9, 8'h00, "R1");
        xfer(0, 0, 0, "R1");

        tag = "R2";
        wr(2, 8'h34); wr(2, 8'h12);
        wr(3, 8'h02); wr(3, 8'h00);
        rd(2, 8'h34, "R2"); rd(2, 8'h12, "R2");
        rd(3, 8'h02, "R2"); rd(3, 8'h00, "R2");

        tag = "R3";
        wr(2, 8'hAA); wr(12, 0); wr(2, 8'h55); wr(12, 0);
        rd(2, 8'h55, "R3"); rd(2, 8'h12, "R3");

        tag = "R6";
        setpage(1, 8'h7E);
        wr(11, 8'h05);
        tag = "R4";
        wr(10, 8'h01);
        tag = "R10";
        xfer(1, 1, 24'h7E1255, "R10");
        xfer(1, 1, 24'h7E1256, "R10");
        tag = "R11";
        xfer(1, 1, 24'h7E1257, "R11");
        xfer(1, 0, 0, "R11");
        idle();
        tag = "R8";
        rd(8, 8'h02, "R8");
        rd(8, 8'h00, "R8");
        tag = "R10";
        xfer(1, 1, 24'h7E1258, "R10");
        rd(3, 8'hFE, "R11");

        tag = "R5";
        wr(9, 8'h06);
        rd(8, 8'h40, "R5");
        tag = "R7";
        wr(8, 8'hFD);
        rd(9, 8'h05, "R7");

        tag = "R12";
        wr(12, 0);
        wr(4, 8'h10); wr(4, 8'h00);
        wr(5, 8'h01); wr(5, 8'h00);
        wr(11, 8'h32);
        setpage(2, 8'h03);
        tag = "R4";
        wr(14, 0);
        tag = "R12";
        xfer(2, 1, 24'h030010, "R6");
        xfer(2, 1, 24'h03000F, "R12");
        xfer(2, 0, 0, "R12");
        idle();
        rd(8, 8'h44, "R8");
        xfer(2, 1, 24'h030010, "R12");

        tag = "R4";
        wr(15, 8'h0B);
        xfer(1, 0, 0, "R4");
        xfer(2, 1, 24'h03000F, "R4");
        wr(10, 8'h06);
        xfer(2, 0, 0, "R4");

        tag = "R13";
        wr(14, 0);
        wr(2, 8'h99);
        wr(13, 0);
        rd(8, 8'h00, "R13");
        rd(2, 8'h99, "R13");
        xfer(2, 0, 0, "R13");
        idle();
        idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule